// File: doc/BRIEF.md
# Carry-Less Polynomial Divider

This block divides one polynomial over GF(2) by another. Bit i of each operand is the coefficient of x^i, and addition is XOR, so no carries or borrows take part. An N_WIDTH-bit dividend and a WIDTH-bit divisor are accepted through a valid/ready input handshake. After a fixed number of clocks, a WIDTH-bit quotient and a WIDTH-bit remainder are offered through a valid/ready output handshake. The block holds them until the consumer takes them.

The division runs as a sequence of max(WIDTH, N_WIDTH) iteration steps, one per quotient bit position, starting from the highest. Each step checks whether the divisor, shifted to that position, has its leading coefficient on a set bit of the partial remainder. If it does, the step XORs the shifted divisor into the remainder and sets that quotient bit. The parameter STEPS_PER_CLOCK chains that many steps combinationally between registers. This trades clock count against logic depth. The capture edge already performs the first group of steps.

The result is undefined in two cases: when the divisor is zero, and when the true quotient has a set bit at position WIDTH or above. The handshake timing is the same in those cases.

Top module: `cldiv_unit`

## Requirements
- R1: A clock edge with rst_n low puts the block in idle, with in_ready = 1 and out_valid = 0, even if an operation is in progress; the interrupted operation never produces a result.
- R2: An operand pair is captured on a rising edge where in_valid and in_ready are both 1. From the next cycle, in_ready stays 0 until the result is released. out_valid stays 0 until the last step has run.
- R3: out_valid rises exactly L clock edges after the capture edge, where L = ceil(max(WIDTH, N_WIDTH) / STEPS_PER_CLOCK) - 1 (L = 0 means out_valid is 1 right after the capture edge).
- R4: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_quotient and out_remainder keep their values.
- R5: On an edge with out_valid = 1 and out_ready = 1, the result is released: in the next cycle out_valid = 0 and in_ready = 1.
- R6: For a nonzero divisor whose quotient fits in WIDTH bits, out_quotient equals the GF(2) polynomial quotient of in_dividend by in_divisor, computed at max(WIDTH, N_WIDTH) bits.
- R7: Under the same condition, out_remainder equals the GF(2) polynomial remainder, whose degree is below that of the divisor.
- R8: After the capture edge, the operand buses and in_valid have no effect on the result; in idle with in_valid = 0 the block stays idle.
- R9: With a zero divisor or an overflowing quotient, the values are unspecified but the handshake follows R2 to R5 with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block is idle and accepts operands |
| in_dividend | input | N_WIDTH | Dividend polynomial, bit i is the x^i coefficient |
| in_divisor | input | WIDTH | Divisor polynomial |
| out_valid | output | 1 | Quotient and remainder are available |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | WIDTH | Polynomial quotient |
| out_remainder | output | WIDTH | Polynomial remainder |

## Verification
The bench builds the block with WIDTH = 4, N_WIDTH = 8 and STEPS_PER_CLOCK = 3. With these values the dividend is wider than the divisor, so quotients can overflow. Eight steps do not divide evenly by three, so the last clock runs a partial group of steps against a saturated step counter, giving L = 2. The small widths make it possible to sweep every one of the 4096 dividend/divisor pairs. Each pair is paired with a different back-pressure hold, and stray in_valid pulses are driven during the busy cycles.

// File: rtl/cldiv_pkg.sv
// Shared definitions for the carry-less divider.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package cldiv_pkg;

    // Handshake phase of the divider
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } cldiv_phase_e;

    // Larger of two elaboration-time values
    function automatic int cldiv_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cldiv_degree.sv
// Priority encoder returning the index of the highest set bit of a vector,
// i.e. the degree of the polynomial it encodes.
// Assumes: WIDTH >= 2; a zero vector yields 0 (its result is don't-care).
module cldiv_degree #(
    parameter int WIDTH = 4,
    parameter int DW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [DW-1:0]    deg
);

    // Scan upward so the last set bit found is the leading one
    always_comb begin
        deg = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) deg = DW'(i);
        end
    end

endmodule

// File: rtl/cldiv_step.sv
// One iteration of GF(2) long division. Step s works on quotient bit
// k = MAXW-1-s. If the divisor, shifted left by k, has its leading
// coefficient on a set remainder bit, the step XORs it into the remainder
// and sets quotient bit k. Once step_i reaches MAXW the step passes its
// inputs through unchanged (saturating).
// Assumes: WIDTH <= MAXW, deg is the degree of dvs.
module cldiv_step #(
    parameter int WIDTH = 4,
    parameter int MAXW  = 8,
    parameter int SW    = $clog2(MAXW + 1),
    parameter int DW    = $clog2(WIDTH)
) (
    input  logic [SW-1:0]    step_i,
    input  logic [MAXW-1:0]  rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs,
    input  logic [DW-1:0]    deg,
    output logic [SW-1:0]    step_o,
    output logic [MAXW-1:0]  rem_o,
    output logic [WIDTH-1:0] quo_o
);

    localparam logic [SW-1:0] LAST  = SW'(MAXW - 1);
    localparam logic [SW:0]   LIMIT = (SW + 1)'(MAXW);

    logic          done;
    logic          hit;
    logic [SW-1:0] k;
    logic [SW:0]   pos;
    logic [MAXW-1:0] lead;

    // Alignment test, conditional XOR and quotient bit for this step
    always_comb begin
        done   = (step_i >= SW'(MAXW));
        k      = LAST - step_i;
        pos    = {1'b0, k} + {{(SW + 1 - DW){1'b0}}, deg};
        lead   = {{(MAXW - 1){1'b0}}, 1'b1} << pos;
        hit    = !done && (pos < LIMIT) && (|(rem_i & lead));
        rem_o  = hit ? (rem_i ^ (MAXW'(dvs) << k)) : rem_i;
        quo_o  = hit ? (quo_i | ({{(WIDTH - 1){1'b0}}, 1'b1} << k)) : quo_i;
        step_o = done ? step_i : (step_i + SW'(1));
    end

endmodule

// File: rtl/cldiv_ctrl.sv
// Handshake control for the divider: idle/run phase, operand capture
// strobe, advance strobe while steps remain, and release on output accept.
// Assumes: done is derived from the registered step counter.
module cldiv_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    input  logic done,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic advance
);

    import cldiv_pkg::*;

    cldiv_phase_e phase;

    // Phase register: idle -> run on capture, run -> idle on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (in_valid)           phase <= PH_RUN;
                PH_RUN:  if (done && out_ready)  phase <= PH_IDLE;
                default:                         phase <= PH_IDLE;
            endcase
        end
    end

    // Strobes and handshake outputs decoded from the phase
    always_comb begin
        in_ready  = (phase == PH_IDLE);
        out_valid = (phase == PH_RUN) && done;
        load      = in_ready && in_valid;
        advance   = (phase == PH_RUN) && !done;
    end

endmodule

// File: rtl/cldiv_unit.sv
// Sequential carry-less (GF(2) polynomial) divider with valid/ready on both
// sides. STEPS_PER_CLOCK step slices are chained per clock; the capture
// edge runs the first group on the incoming operands.
// Assumes: WIDTH >= 2, N_WIDTH >= 1, STEPS_PER_CLOCK >= 1. Results for a
// zero divisor or an overflowing quotient are unspecified.
module cldiv_unit #(
    parameter int WIDTH           = 4,
    parameter int N_WIDTH         = 8,
    parameter int STEPS_PER_CLOCK = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [N_WIDTH-1:0] in_dividend,
    input  logic [WIDTH-1:0]   in_divisor,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WIDTH-1:0]   out_quotient,
    output logic [WIDTH-1:0]   out_remainder
);

    localparam int MAXW = cldiv_pkg::cldiv_max(WIDTH, N_WIDTH);
    localparam int SW   = $clog2(MAXW + 1);
    localparam int DW   = $clog2(WIDTH);
    localparam int S    = STEPS_PER_CLOCK;

    logic             load;
    logic             advance;
    logic             done;

    logic [SW-1:0]    st_step;
    logic [MAXW-1:0]  st_rem;
    logic [WIDTH-1:0] st_quo;
    logic [WIDTH-1:0] st_dvs;

    logic [WIDTH-1:0] src_dvs;
    logic [DW-1:0]    src_deg;

    logic [SW-1:0]    ch_step [S + 1];
    logic [MAXW-1:0]  ch_rem  [S + 1];
    logic [WIDTH-1:0] ch_quo  [S + 1];

    assign done = (st_step >= SW'(MAXW));

    cldiv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .done      (done),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .advance   (advance)
    );

    // Chain head: fresh operands on capture, otherwise the held state
    assign src_dvs    = load ? in_divisor : st_dvs;
    assign ch_step[0] = load ? '0 : st_step;
    assign ch_rem[0]  = load ? MAXW'(in_dividend) : st_rem;
    assign ch_quo[0]  = load ? '0 : st_quo;

    cldiv_degree #(
        .WIDTH (WIDTH),
        .DW    (DW)
    ) u_deg (
        .vec (src_dvs),
        .deg (src_deg)
    );

    for (genvar g = 0; g < S; g++) begin : g_step
        cldiv_step #(
            .WIDTH (WIDTH),
            .MAXW  (MAXW),
            .SW    (SW),
            .DW    (DW)
        ) u_step (
            .step_i (ch_step[g]),
            .rem_i  (ch_rem[g]),
            .quo_i  (ch_quo[g]),
            .dvs    (src_dvs),
            .deg    (src_deg),
            .step_o (ch_step[g+1]),
            .rem_o  (ch_rem[g+1]),
            .quo_o  (ch_quo[g+1])
        );
    end

    // Step state register: updated on capture and while steps remain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_step <= '0;
            st_rem  <= '0;
            st_quo  <= '0;
        end else if (load || advance) begin
            st_step <= ch_step[S];
            st_rem  <= ch_rem[S];
            st_quo  <= ch_quo[S];
        end
    end

    // Divisor register: latched once per operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_dvs <= '0;
        end else if (load) begin
            st_dvs <= in_divisor;
        end
    end

    assign out_quotient  = st_quo;
    assign out_remainder = st_rem[WIDTH-1:0];

endmodule

// File: rtl/cldiv_checker.sv
// Protocol and timing checker for cldiv_unit, attached by bind.
// Assumes: the parameters match the bound instance.
module cldiv_checker #(
    parameter int WIDTH           = 4,
    parameter int N_WIDTH         = 8,
    parameter int STEPS_PER_CLOCK = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [WIDTH-1:0] out_quotient,
    input logic [WIDTH-1:0] out_remainder
);

    localparam int MAXW = (WIDTH > N_WIDTH) ? WIDTH : N_WIDTH;
    localparam int LAT  = (MAXW + STEPS_PER_CLOCK - 1) / STEPS_PER_CLOCK - 1;

    int busy_run;

    // Count consecutive busy cycles since the last idle cycle
    always_ff @(posedge clk) begin
        if (!rst_n || in_ready) busy_run <= 0;
        else if (!out_valid)    busy_run <= busy_run + 1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    // R2
    capture_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (busy_run == LAT));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_quotient) && $stable(out_remainder)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    // R8
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (in_ready && !out_valid));

endmodule

bind cldiv_unit cldiv_checker #(
    .WIDTH           (WIDTH),
    .N_WIDTH         (N_WIDTH),
    .STEPS_PER_CLOCK (STEPS_PER_CLOCK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_quotient  (out_quotient),
    .out_remainder (out_remainder)
);

// File: tb/sim_cldiv_unit.sv
// Scoreboard bench for cldiv_unit: a driver task queues expected items,
// a monitor process checks each result as it appears.
module sim_cldiv_unit;

    localparam int W   = 4;
    localparam int NW  = 8;
    localparam int S   = 3;
    localparam int MW  = (W > NW) ? W : NW;
    localparam int LAT = (MW + S - 1) / S - 1;

    typedef struct {
        logic [NW-1:0] n;
        logic [W-1:0]  d;
        int            hold;
        int            cap;
    } item_t;

    logic          clk;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [NW-1:0] in_dividend;
    logic [W-1:0]  in_divisor;
    logic          out_valid;
    logic          out_ready;
    logic [W-1:0]  out_quotient;
    logic [W-1:0]  out_remainder;

    item_t sb[$];
    int    cyc = 0;
    int    nchk = 0;
    int    nfail = 0;
    bit    finished = 0;

    cldiv_unit #(.WIDTH(W), .N_WIDTH(NW), .STEPS_PER_CLOCK(S)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_dividend   (in_dividend),
        .in_divisor    (in_divisor),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_quotient  (out_quotient),
        .out_remainder (out_remainder)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent GF(2) long division, bit position by bit position
    function automatic void cl_ref(input logic [MW-1:0] n, input logic [W-1:0] d,
                                   output logic [MW-1:0] q, output logic [MW-1:0] r);
        int dg;
        logic [MW-1:0] de;
        r  = n;
        q  = '0;
        de = MW'(d);
        dg = -1;
        for (int i = 0; i < W; i++) if (d[i]) dg = i;
        for (int b = MW - 1; b >= 0; b--) begin
            if (dg >= 0 && b >= dg && r[b]) begin
                r = r ^ (de << (b - dg));
                q[b - dg] = 1'b1;
            end
        end
    endfunction

    // Driver: present one pair, queue it, disturb the bus while busy (R8)
    task automatic send(input logic [NW-1:0] n, input logic [W-1:0] d, input int hold);
        item_t it;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid    = 1'b1;
        in_dividend = n;
        in_divisor  = d;
        it.n = n; it.d = d; it.hold = hold; it.cap = cyc + 1;
        sb.push_back(it);
        for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            check(!in_ready && !out_valid, "R2", "busy after capture",
                  {30'd0, in_ready, out_valid}, 32'd0);
            in_valid    = (k < LAT - 1);
            in_dividend = ~n;
            in_divisor  = ~d;
        end
        if (LAT == 0) @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each result, apply back-pressure, check release
    initial begin
        item_t it;
        logic [MW-1:0] eq, er;
        logic [W-1:0]  hq, hr;
        bit fits;
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "result without capture", 32'd1, 32'd0);
                end else begin
                    it = sb.pop_front();
                    cl_ref(MW'(it.n), it.d, eq, er);
                    fits = (it.d != 0) && ((eq >> W) == 0);
                    check(cyc == it.cap + LAT, fits ? "R3" : "R9", "latency",
                          cyc - it.cap, LAT);
                    if (fits) begin
                        check(out_quotient == eq[W-1:0], "R6", "quotient",
                              out_quotient, eq[W-1:0]);
                        check(out_remainder == er[W-1:0], "R7", "remainder",
                              out_remainder, er[W-1:0]);
                    end
                    hq = out_quotient;
                    hr = out_remainder;
                    for (int h = 0; h < it.hold; h++) begin
                        @(negedge clk);
                        check(out_valid && out_quotient == hq && out_remainder == hr,
                              "R4", "hold under back-pressure",
                              {out_valid, 23'd0, out_quotient, out_remainder},
                              {1'b1, 23'd0, hq, hr});
                    end
                    out_ready = 1'b1;
                    @(negedge clk);
                    out_ready = 1'b0;
                    check(!out_valid && in_ready, "R5", "release",
                          {30'd0, out_valid, in_ready}, 32'd1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // Main sequence
    initial begin
        rst_n       = 1'b0;
        in_valid    = 1'b0;
        out_ready   = 1'b0;
        in_dividend = '0;
        in_divisor  = '0;
        repeat (3) @(negedge clk);
        check(in_ready && !out_valid, "R1", "reset state",
              {30'd0, in_ready, out_valid}, 32'd2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(in_ready && !out_valid, "R8", "idle with no request",
              {30'd0, in_ready, out_valid}, 32'd2);

        // directed: exact, with remainder, zero divisor, overflow
        send(8'h0F, 4'h3, 2);
        send(8'h35, 4'h7, 0);
        send(8'h5A, 4'h0, 1);
        send(8'hFF, 4'h1, 0);

        // exhaustive sweep with varying back-pressure
        for (int n = 0; n < (1 << NW); n++) begin
            for (int d = 0; d < (1 << W); d++) begin
                send(NW'(n), W'(d), (n + d) % 3);
            end
        end

        @(negedge clk);
        while (sb.size() != 0 || !in_ready) @(negedge clk);

        // R1: reset during a running operation returns to idle
        in_valid    = 1'b1;
        in_dividend = 8'h9C;
        in_divisor  = 4'h5;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(in_ready && !out_valid, "R1", "reset while busy",
              {30'd0, in_ready, out_valid}, 32'd2);
        repeat (LAT + 2) @(negedge clk);
        check(in_ready && !out_valid, "R1", "no result after reset",
              {30'd0, in_ready, out_valid}, 32'd2);

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule